// File: doc/BRIEF.md
# Random Work-Stealing Request Engine

This block sits beside each tile of a many-core chip and moves runnable threads from busy tiles to idle ones. While the local core reports that it has nothing to run, the engine draws a victim tile at random, never its own, and sends it one steal request. It then waits for the answer. A positive answer carries a thread descriptor, which the engine installs into the local thread table. A negative answer, or no answer within a bounded number of cycles, makes it draw a fresh victim at once while the core is still idle.

The same block also serves requests from other tiles. It looks at the local thread table, which reports whether it holds a thread that can be given away (one in the ready or blocked state). It then answers either with that thread's descriptor, removing the entry in the same cycle, or with a refusal. The descriptor is opaque here: it stands for the thread entry, its queue bindings and its context. Random draws come from an internal 16-bit LFSR. The result is reduced modulo the number of other tiles and then mapped around the tile's own index. A build for a single tile never sends requests, so its threads are run locally in the order the table keeps them.

Top module: `steal_engine`

## Requirements
- R1: After reset, the outgoing request valid, the outgoing reply valid, the table install strobe and the table remove strobe are all 0.
- R2: While in its waiting-free state with core_idle high, the engine raises steal_req_valid for one cycle, one clock edge later. steal_req_dst is below NUM_TILES and never equals TILE_ID. With core_idle low, no request is raised.
- R3: Across repeated retries, every tile other than TILE_ID is chosen as a victim. The victim is an LFSR value modulo NUM_TILES-1, with values at or above TILE_ID shifted up by one.
- R4: At most one request is outstanding. After a request, no further request is raised until a reply arrives or the timeout expires.
- R5: A negative reply (steal_rsp_valid high, steal_rsp_ok low) while waiting raises a new request on the next edge if core_idle is high. If core_idle is low, the engine returns to its waiting-free state and raises nothing.
- R6: With no reply, a new request is raised exactly TIMEOUT_CYC cycles after the previous one, as if a negative reply had arrived.
- R7: A positive reply while waiting pulses tbl_install for one cycle, on the next edge, with tbl_install_desc equal to the reply descriptor, and ends the wait.
- R8: A reply that arrives when no request is outstanding is ignored: no install and no request follow.
- R9: An incoming steal request (inbound_req_valid) is answered one cycle later with inbound_rsp_valid high and inbound_rsp_dst equal to the requester's tile index. The reply is positive (inbound_rsp_ok high, inbound_rsp_desc equal to tbl_spare_desc) when tbl_has_spare is high, and negative otherwise. Back-to-back requests get back-to-back replies.
- R10: tbl_remove is high exactly in the cycles in which a positive reply is issued, and never with a negative reply.
- R11: With NUM_TILES equal to 1, steal_req_valid stays 0 whatever core_idle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_idle | input | 1 | Local core has no thread to run |
| steal_req_valid | output | 1 | Outgoing steal request strobe |
| steal_req_dst | output | TILE_W | Victim tile of the outgoing request |
| steal_rsp_valid | input | 1 | Reply to our request arrives |
| steal_rsp_ok | input | 1 | Reply carries a thread |
| steal_rsp_desc | input | DESC_W | Stolen thread descriptor |
| inbound_req_valid | input | 1 | Steal request from another tile |
| inbound_req_src | input | TILE_W | Tile that sent the inbound request |
| inbound_rsp_valid | output | 1 | Reply to an inbound request |
| inbound_rsp_dst | output | TILE_W | Tile the reply goes to |
| inbound_rsp_ok | output | 1 | Reply hands over a thread |
| inbound_rsp_desc | output | DESC_W | Descriptor handed over (0 on refusal) |
| tbl_has_spare | input | 1 | Local table holds a ready or blocked thread |
| tbl_spare_desc | input | DESC_W | Descriptor of that thread |
| tbl_remove | output | 1 | Remove the spare thread from the local table |
| tbl_install | output | 1 | Install a stolen thread into the local table |
| tbl_install_desc | output | DESC_W | Descriptor to install |

## Verification
The requester is driven with a busy core, with an idle core that gets no answer, with a stream of refusals and with a positive answer. Silence versus refusal separates the timeout path from the immediate retry. The refusal stream also shows whether the random victims cover every other tile and skip the own index. A stray answer with no request outstanding must leave the table untouched. The responder gets inbound requests with and without a spare thread and two back to back, which separates a correct removal strobe from one that fires on refusals or merges adjacent requests. A separate single-tile instance held idle shows that no request ever leaves.

// File: rtl/sw_pkg.sv
package sw_pkg;
   typedef enum logic {
      REQ_FREE = 1'b0,
      REQ_WAIT = 1'b1
   } req_state_t;
endpackage

// File: rtl/sw_lfsr.sv
module sw_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] value
);
   if (SEED == '0) begin : g_bad_seed
      $error("sw_lfsr: SEED must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) value <= SEED;
      else if (value[0]) value <= (value >> 1) ^ TAPS;
      else value <= value >> 1;
   end

   p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      value != '0);
endmodule

// File: rtl/sw_victim_sel.sv
module sw_victim_sel #(
   parameter int NUM_TILES = 4,
   parameter int TILE_ID   = 0,
   parameter int RND_W     = 16,
   parameter int TILE_W    = 2
) (
   input  logic [RND_W-1:0]  rnd,
   output logic [TILE_W-1:0] victim
);
   localparam int OTHERS = NUM_TILES - 1;

   if (OTHERS < 1) begin : g_bad_count
      $error("sw_victim_sel: needs at least two tiles");
   end

   logic [RND_W-1:0] slot;

   assign slot   = rnd % RND_W'(OTHERS);
   assign victim = (slot >= RND_W'(TILE_ID)) ? TILE_W'(slot + 1'b1) : TILE_W'(slot);
endmodule

// File: rtl/sw_requester.sv
module sw_requester
   import sw_pkg::*;
#(
   parameter int NUM_TILES   = 4,
   parameter int TILE_ID     = 0,
   parameter int TILE_W      = 2,
   parameter int DESC_W      = 32,
   parameter int TIMEOUT_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_idle,
   input  logic [TILE_W-1:0] victim,
   input  logic              rsp_valid,
   input  logic              rsp_ok,
   input  logic [DESC_W-1:0] rsp_desc,
   output logic              req_valid,
   output logic [TILE_W-1:0] req_dst,
   output logic              inst_valid,
   output logic [DESC_W-1:0] inst_desc
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

   req_state_t       state;
   logic [CNT_W-1:0] timer;
   logic             expired;
   logic             retry;

   assign expired = (timer == CNT_W'(TIMEOUT_CYC - 1));
   assign retry   = (state == REQ_WAIT) && !(rsp_valid && rsp_ok) && (rsp_valid || expired);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= REQ_FREE;
         timer      <= '0;
         req_valid  <= 1'b0;
         req_dst    <= '0;
         inst_valid <= 1'b0;
         inst_desc  <= '0;
      end else begin
         req_valid  <= 1'b0;
         inst_valid <= 1'b0;
         if ((state == REQ_FREE || retry) && core_idle) begin
            req_valid <= 1'b1;
            req_dst   <= victim;
            timer     <= '0;
            state     <= REQ_WAIT;
         end else if (retry) begin
            state <= REQ_FREE;
         end else if (state == REQ_WAIT && rsp_valid && rsp_ok) begin
            inst_valid <= 1'b1;
            inst_desc  <= rsp_desc;
            state      <= REQ_FREE;
         end else if (state == REQ_WAIT) begin
            timer <= timer + 1'b1;
         end
      end
   end

   p_victim_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_dst != TILE_W'(TILE_ID)) && (32'(req_dst) < NUM_TILES));
   p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> !req_valid);
   p_install_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid |-> $past(rsp_valid && rsp_ok));
   p_ack_ends_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == REQ_WAIT && rsp_valid && rsp_ok) |=> !req_valid);
endmodule

// File: rtl/sw_responder.sv
module sw_responder #(
   parameter int TILE_W = 2,
   parameter int DESC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [TILE_W-1:0] in_src,
   input  logic              has_spare,
   input  logic [DESC_W-1:0] spare_desc,
   output logic              rsp_valid,
   output logic [TILE_W-1:0] rsp_dst,
   output logic              rsp_ok,
   output logic [DESC_W-1:0] rsp_desc,
   output logic              remove
);
   logic              pend;
   logic [TILE_W-1:0] pend_src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         pend_src <= '0;
      end else begin
         pend     <= in_valid;
         pend_src <= in_src;
      end
   end

   assign rsp_valid = pend;
   assign rsp_dst   = pend_src;
   assign rsp_ok    = pend && has_spare;
   assign rsp_desc  = rsp_ok ? spare_desc : '0;
   assign remove    = rsp_ok;

   p_reply_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(in_valid));
   p_reply_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_dst == $past(in_src));
   p_remove_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (remove && !in_valid) |=> !remove);
endmodule

// File: rtl/steal_engine.sv
module steal_engine #(
   parameter int          NUM_TILES   = 4,
   parameter int          TILE_ID     = 0,
   parameter int          TILE_W      = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
   parameter int          DESC_W      = 32,
   parameter int          TIMEOUT_CYC = 16,
   parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_idle,
   output logic              steal_req_valid,
   output logic [TILE_W-1:0] steal_req_dst,
   input  logic              steal_rsp_valid,
   input  logic              steal_rsp_ok,
   input  logic [DESC_W-1:0] steal_rsp_desc,
   input  logic              inbound_req_valid,
   input  logic [TILE_W-1:0] inbound_req_src,
   output logic              inbound_rsp_valid,
   output logic [TILE_W-1:0] inbound_rsp_dst,
   output logic              inbound_rsp_ok,
   output logic [DESC_W-1:0] inbound_rsp_desc,
   input  logic              tbl_has_spare,
   input  logic [DESC_W-1:0] tbl_spare_desc,
   output logic              tbl_remove,
   output logic              tbl_install,
   output logic [DESC_W-1:0] tbl_install_desc
);
   localparam int RND_W = 16;

   if (NUM_TILES < 1 || TILE_ID < 0 || TILE_ID >= NUM_TILES) begin : g_bad_id
      $error("steal_engine: TILE_ID must lie in 0..NUM_TILES-1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("steal_engine: TIMEOUT_CYC must be at least 2");
   end
   if ((1 << TILE_W) < NUM_TILES) begin : g_bad_width
      $error("steal_engine: TILE_W too narrow for NUM_TILES");
   end

   if (NUM_TILES > 1) begin : g_steal
      logic [RND_W-1:0]  rnd;
      logic [TILE_W-1:0] victim;

      sw_lfsr #(.W(RND_W), .SEED(LFSR_SEED)) u_lfsr (
         .clk(clk), .rst_n(rst_n), .value(rnd));

      sw_victim_sel #(.NUM_TILES(NUM_TILES), .TILE_ID(TILE_ID),
                      .RND_W(RND_W), .TILE_W(TILE_W)) u_sel (
         .rnd(rnd), .victim(victim));

      sw_requester #(.NUM_TILES(NUM_TILES), .TILE_ID(TILE_ID), .TILE_W(TILE_W),
                     .DESC_W(DESC_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_req (
         .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .victim(victim),
         .rsp_valid(steal_rsp_valid), .rsp_ok(steal_rsp_ok), .rsp_desc(steal_rsp_desc),
         .req_valid(steal_req_valid), .req_dst(steal_req_dst),
         .inst_valid(tbl_install), .inst_desc(tbl_install_desc));
   end else begin : g_solo
      assign steal_req_valid  = 1'b0;
      assign steal_req_dst    = '0;
      assign tbl_install      = 1'b0;
      assign tbl_install_desc = '0;
   end

   sw_responder #(.TILE_W(TILE_W), .DESC_W(DESC_W)) u_rsp (
      .clk(clk), .rst_n(rst_n),
      .in_valid(inbound_req_valid), .in_src(inbound_req_src),
      .has_spare(tbl_has_spare), .spare_desc(tbl_spare_desc),
      .rsp_valid(inbound_rsp_valid), .rsp_dst(inbound_rsp_dst),
      .rsp_ok(inbound_rsp_ok), .rsp_desc(inbound_rsp_desc),
      .remove(tbl_remove));

   p_remove_needs_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_remove |-> $past(inbound_req_valid));
endmodule

// File: tb/steal_engine_test.sv
module steal_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NT  = 4;
   localparam int TID = 2;
   localparam int TW  = 2;
   localparam int DW  = 32;
   localparam int TO  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_idle = 1'b0;
   logic rsp_valid = 1'b0, rsp_ok = 1'b0;
   logic [DW-1:0] rsp_desc = '0;
   logic in_valid = 1'b0;
   logic [TW-1:0] in_src = '0;
   logic has_spare = 1'b0;
   logic [DW-1:0] spare_desc = '0;

   logic req_valid, ib_valid, ib_ok, t_remove, t_install;
   logic [TW-1:0] req_dst, ib_dst;
   logic [DW-1:0] ib_desc, inst_desc;

   logic solo_idle = 1'b0;
   logic solo_req, solo_ib_valid, solo_ib_ok, solo_remove, solo_install;
   logic [0:0] solo_dst, solo_ib_dst;
   logic [DW-1:0] solo_ib_desc, solo_inst_desc;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   steal_engine #(.NUM_TILES(NT), .TILE_ID(TID), .TILE_W(TW), .DESC_W(DW),
                  .TIMEOUT_CYC(TO)) uut (
      .clk(clk), .rst_n(rst_n), .core_idle(core_idle),
      .steal_req_valid(req_valid), .steal_req_dst(req_dst),
      .steal_rsp_valid(rsp_valid), .steal_rsp_ok(rsp_ok), .steal_rsp_desc(rsp_desc),
      .inbound_req_valid(in_valid), .inbound_req_src(in_src),
      .inbound_rsp_valid(ib_valid), .inbound_rsp_dst(ib_dst),
      .inbound_rsp_ok(ib_ok), .inbound_rsp_desc(ib_desc),
      .tbl_has_spare(has_spare), .tbl_spare_desc(spare_desc),
      .tbl_remove(t_remove), .tbl_install(t_install), .tbl_install_desc(inst_desc));

   steal_engine #(.NUM_TILES(1), .TILE_ID(0), .TILE_W(1), .DESC_W(DW),
                  .TIMEOUT_CYC(TO)) uut_solo (
      .clk(clk), .rst_n(rst_n), .core_idle(solo_idle),
      .steal_req_valid(solo_req), .steal_req_dst(solo_dst),
      .steal_rsp_valid(1'b0), .steal_rsp_ok(1'b0), .steal_rsp_desc('0),
      .inbound_req_valid(1'b0), .inbound_req_src(1'b0),
      .inbound_rsp_valid(solo_ib_valid), .inbound_rsp_dst(solo_ib_dst),
      .inbound_rsp_ok(solo_ib_ok), .inbound_rsp_desc(solo_ib_desc),
      .tbl_has_spare(1'b0), .tbl_spare_desc('0),
      .tbl_remove(solo_remove), .tbl_install(solo_install), .tbl_install_desc(solo_inst_desc));

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // return the requester to its free state with the core busy
   task automatic go_home();
      core_idle = 1'b0;
      rsp_valid = 1'b1; rsp_ok = 1'b1; rsp_desc = 32'h0;
      tick();
      rsp_valid = 1'b0; rsp_ok = 1'b0;
      tick();
      tick();
   endtask

   task automatic t_reset();
      check(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
      check(ib_valid == 1'b0, "R1 inbound_rsp_valid", ib_valid, 0);
      check(t_install == 1'b0, "R1 tbl_install", t_install, 0);
      check(t_remove == 1'b0, "R1 tbl_remove", t_remove, 0);
      for (int i = 0; i < 6; i++) begin
         tick();
         check(req_valid == 1'b0, "R2 busy core no request", req_valid, 0);
      end
   endtask

   task automatic t_timeout();
      core_idle = 1'b1;
      tick();
      check(req_valid == 1'b1, "R2 idle request", req_valid, 1);
      check(req_dst != TW'(TID) && 32'(req_dst) < NT, "R2 victim legal", req_dst, 0);
      for (int k = 1; k < TO; k++) begin
         tick();
         check(req_valid == 1'b0, "R4 single outstanding", req_valid, 0);
      end
      tick();
      check(req_valid == 1'b1, "R6 timeout retry", req_valid, 1);
      go_home();
   endtask

   task automatic t_nack();
      logic [NT-1:0] seen = '0;
      core_idle = 1'b1;
      tick();
      check(req_valid == 1'b1, "R2 idle request", req_valid, 1);
      seen[req_dst] = 1'b1;
      for (int i = 0; i < 60; i++) begin
         rsp_valid = 1'b1; rsp_ok = 1'b0;
         tick();
         rsp_valid = 1'b0;
         if (!req_valid) check(1'b0, "R5 retry after nack", req_valid, 1);
         if (req_dst == TW'(TID)) check(1'b0, "R2 victim not self", req_dst, 99);
         seen[req_dst] = 1'b1;
      end
      check(seen == 4'b1011, "R3 victim coverage", seen, 4'b1011);
      rsp_valid = 1'b1; rsp_ok = 1'b0; core_idle = 1'b0;
      tick();
      rsp_valid = 1'b0;
      check(req_valid == 1'b0, "R5 nack busy no retry", req_valid, 0);
      for (int i = 0; i < 2 * TO; i++) begin
         tick();
         if (req_valid) check(1'b0, "R5 stays free after nack", req_valid, 0);
      end
      check(req_valid == 1'b0, "R5 quiet after nack", req_valid, 0);
   endtask

   task automatic t_ack();
      core_idle = 1'b1;
      tick();
      check(req_valid == 1'b1, "R2 idle request", req_valid, 1);
      rsp_valid = 1'b1; rsp_ok = 1'b1; rsp_desc = 32'hCAFE_0123; core_idle = 1'b0;
      tick();
      rsp_valid = 1'b0; rsp_ok = 1'b0;
      check(t_install == 1'b1, "R7 install pulse", t_install, 1);
      check(inst_desc == 32'hCAFE_0123, "R7 install desc", inst_desc, 32'hCAFE_0123);
      check(req_valid == 1'b0, "R7 no request after ack", req_valid, 0);
      tick();
      check(t_install == 1'b0, "R7 install one cycle", t_install, 0);
      rsp_valid = 1'b1; rsp_ok = 1'b1; rsp_desc = 32'h5555_AAAA;
      tick();
      rsp_valid = 1'b0; rsp_ok = 1'b0;
      check(t_install == 1'b0, "R8 stray reply ignored", t_install, 0);
      tick();
      check(t_install == 1'b0 && req_valid == 1'b0, "R8 stray reply no action", t_install, 0);
   endtask

   task automatic t_responder();
      has_spare = 1'b1; spare_desc = 32'h1234_5678;
      in_valid = 1'b1; in_src = 2'd1;
      tick();
      in_valid = 1'b0;
      check(ib_valid == 1'b1 && ib_dst == 2'd1, "R9 reply to src 1", ib_dst, 1);
      check(ib_ok == 1'b1 && ib_desc == 32'h1234_5678, "R9 positive desc", ib_desc, 32'h1234_5678);
      check(t_remove == 1'b1, "R10 remove with ack", t_remove, 1);
      tick();
      check(ib_valid == 1'b0 && t_remove == 1'b0, "R10 single remove", t_remove, 0);
      has_spare = 1'b0;
      in_valid = 1'b1; in_src = 2'd3;
      tick();
      in_valid = 1'b0;
      check(ib_valid == 1'b1 && ib_dst == 2'd3 && ib_ok == 1'b0, "R9 negative reply", ib_ok, 0);
      check(t_remove == 1'b0, "R10 no remove on nack", t_remove, 0);
      has_spare = 1'b1; spare_desc = 32'h0000_BEEF;
      in_valid = 1'b1; in_src = 2'd0;
      tick();
      in_src = 2'd3;
      check(ib_valid && ib_dst == 2'd0 && t_remove, "R9 back-to-back first", ib_dst, 0);
      tick();
      in_valid = 1'b0;
      check(ib_valid && ib_dst == 2'd3 && t_remove, "R9 back-to-back second", ib_dst, 3);
      tick();
      check(ib_valid == 1'b0 && t_remove == 1'b0, "R10 remove ends", t_remove, 0);
      has_spare = 1'b0;
   endtask

   task automatic t_solo();
      solo_idle = 1'b1;
      for (int i = 0; i < 30; i++) begin
         tick();
         if (solo_req) check(1'b0, "R11 solo request", solo_req, 0);
      end
      check(solo_req == 1'b0, "R11 solo quiet", solo_req, 0);
      solo_idle = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_timeout();
      t_nack();
      t_ack();
      t_responder();
      t_solo();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule